// File: doc/BRIEF.md
# Lane Bit Aligner

This block removes whole-bit skew from one receive lane before a finer stage corrects the sub-bit phase error. Each clock it takes in a five-bit parallel word and shifts it into a fifteen-bit history register. A four-bit skew code then picks one run of five consecutive stream bits from that history, together with the newest word, and registers it as the aligned output word. Lanes whose optical paths differ in length then line up to the bit once each lane is given its own code.

The skew code runs from 0 to 14. Each step adds one bit of delay. Code 7 is the nominal alignment, so the codes reach seven bits earlier or seven bits later than nominal. Code 15 is not a valid offset and is handled as 14. The code is registered before it steers the selector. A change is therefore seen in the second output word after the code is driven, and the first of those two words still uses the old code. Reset empties the history, so stream positions from before reset read as zero.

Top module: `lane_bit_aligner`

## Requirements
- R1: While reset is low, `lane_dout` is 0 and the history holds zeros. The first edge after reset uses code 7, whatever `skew_code` is driven to.
- R2: Bit 0 of a word is the earliest bit of that word in the stream, for both `lane_din` and `lane_dout`. With code 0, output bit j (j>0) equals input bit j−1 of the word taken at the same edge, and output bit 0 equals bit 4 of the word before it.
- R3: Number the input words k = 0, 1, … from the first edge after reset, with stream position 5k+j for bit j. The output registered at edge k then has bit j equal to stream position 5k+j−1−c, where c is the effective code (0 to 14).
- R4: A driven code of 15 gives exactly the output of code 14.
- R5: A code present at edge m controls the output registered at edge m+1. The output registered at edge m itself still uses the code captured one edge earlier.
- R6: A stream position below 0 (before the first word after reset) reads as 0 in the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_din | input | 5 | Incoming word, bit 0 earliest |
| skew_code | input | 4 | Alignment code, 0..14 (15 acts as 14), 7 nominal |
| lane_dout | output | 5 | Registered aligned word, bit 0 earliest |

## Verification
The hardest situations to reach from the ports are the edge at which a new code is captured but not yet in use, and the deepest code reaching back into history that reset has just zeroed. The stimulus moves through every code with a fresh random stream and checks the first two words after each switch on their own. It also applies reset in the middle of a stream and follows it at once with the deepest code, so the output has to show zeros until real stream bits arrive at that depth. All expected words come from a record of the driven bits, indexed by the delay formula of R3.

// File: rtl/lba_pkg.sv
package lba_pkg;
   localparam int unsigned LBA_LANE_W_DEF = 5;
   localparam int unsigned LBA_HIST_W_DEF = 15;
   localparam int unsigned LBA_CODE_W_DEF = 4;

   // Width of the span the selector reads: history plus all but the last new bit.
   function automatic int unsigned lba_src_width(input int unsigned hist_w,
                                                 input int unsigned lane_w);
      return hist_w + lane_w - 1;
   endfunction
endpackage

// File: rtl/lba_code_reg.sv
module lba_code_reg #(
   parameter int unsigned HIST_W = lba_pkg::LBA_HIST_W_DEF,
   parameter int unsigned CODE_W = lba_pkg::LBA_CODE_W_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_q
);
   localparam logic [CODE_W-1:0] TOP_CODE    = CODE_W'(HIST_W - 1);
   localparam logic [CODE_W-1:0] CENTRE_CODE = CODE_W'((HIST_W - 1) / 2);

   if (HIST_W > (1 << CODE_W)) begin : g_bad_code_w
      $error("lba_code_reg: CODE_W too narrow for HIST_W taps");
   end

   logic [CODE_W-1:0] code_sat;

   always_comb begin
      code_sat = (code_in > TOP_CODE) ? TOP_CODE : code_in;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= CENTRE_CODE;
      else         code_q <= code_sat;
   end

   // R4: the registered code never leaves the tap range
   a_r4_code_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_q <= TOP_CODE);

   // R5: a code held steady across an edge leaves the steering code unchanged one edge later
   a_r5_hold_when_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $stable(code_in)) |=> $stable(code_q));
endmodule

// File: rtl/lba_history.sv
module lba_history #(
   parameter int unsigned LANE_W = lba_pkg::LBA_LANE_W_DEF,
   parameter int unsigned HIST_W = lba_pkg::LBA_HIST_W_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [LANE_W-1:0] word_in,
   output logic [HIST_W-1:0] hist_q
);
   if (HIST_W < 2 * LANE_W) begin : g_bad_depth
      $error("lba_history: HIST_W must hold at least two words");
   end

   // Newest word enters at the top, oldest bits fall off the bottom.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {word_in, hist_q[HIST_W-1:LANE_W]};
   end

   // R1: reset leaves an empty history
   a_r1_hist_cleared: assert property (@(posedge clk_i)
      !rst_ni |=> (hist_q == '0));

   // R2: bits move toward the low end one word per edge, keeping their order
   a_r2_shift_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (hist_q[LANE_W-1:0] == $past(hist_q[2*LANE_W-1:LANE_W])));
endmodule

// File: rtl/lba_window_mux.sv
module lba_window_mux #(
   parameter int unsigned LANE_W     = lba_pkg::LBA_LANE_W_DEF,
   parameter int unsigned HIST_W     = lba_pkg::LBA_HIST_W_DEF,
   parameter int unsigned CODE_W     = lba_pkg::LBA_CODE_W_DEF,
   parameter bit          MUX_ONEHOT = 1'b0,
   localparam int unsigned SRC_W     = lba_pkg::lba_src_width(HIST_W, LANE_W)
) (
   input  logic [SRC_W-1:0]  src,
   input  logic [CODE_W-1:0] code,
   output logic [LANE_W-1:0] slice
);
   localparam int unsigned NUM_TAPS = HIST_W;

   if (MUX_ONEHOT) begin : g_onehot
      logic [NUM_TAPS-1:0] hit;
      logic [LANE_W-1:0]   term [NUM_TAPS];
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
         // code t reaches back t+1 bits, so its window starts t places below the top window
         assign hit[t]  = (code == CODE_W'(t));
         assign term[t] = {LANE_W{hit[t]}} & src[(HIST_W-1-t) +: LANE_W];
      end
      always_comb begin
         slice = '0;
         for (int t = 0; t < NUM_TAPS; t++) slice = slice | term[t];
      end
   end else begin : g_indexed
      always_comb begin
         slice = '0;
         for (int t = 0; t < NUM_TAPS; t++) begin
            if (code == CODE_W'(t)) slice = src[(HIST_W-1-t) +: LANE_W];
         end
      end
   end
endmodule

// File: rtl/lane_bit_aligner.sv
module lane_bit_aligner #(
   parameter int unsigned LANE_W     = lba_pkg::LBA_LANE_W_DEF,
   parameter int unsigned HIST_W     = lba_pkg::LBA_HIST_W_DEF,
   parameter int unsigned CODE_W     = lba_pkg::LBA_CODE_W_DEF,
   parameter bit          MUX_ONEHOT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [LANE_W-1:0] lane_din,
   input  logic [CODE_W-1:0] skew_code,
   output logic [LANE_W-1:0] lane_dout
);
   localparam int unsigned SRC_W = lba_pkg::lba_src_width(HIST_W, LANE_W);

   if (LANE_W < 2) begin : g_bad_lane
      $error("lane_bit_aligner: LANE_W must be at least 2");
   end
   if (HIST_W % 2 == 0) begin : g_bad_centre
      $error("lane_bit_aligner: HIST_W must be odd so a centre code exists");
   end

   logic [CODE_W-1:0] code_q;
   logic [HIST_W-1:0] hist_q;
   logic [SRC_W-1:0]  src;
   logic [LANE_W-1:0] slice;

   lba_code_reg #(.HIST_W(HIST_W), .CODE_W(CODE_W)) u_code (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_in(skew_code),
      .code_q (code_q)
   );

   lba_history #(.LANE_W(LANE_W), .HIST_W(HIST_W)) u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .word_in(lane_din),
      .hist_q (hist_q)
   );

   // The newest bit of the arriving word is never selected: the shallowest code delays by one bit.
   assign src = {lane_din[LANE_W-2:0], hist_q};

   lba_window_mux #(
      .LANE_W(LANE_W), .HIST_W(HIST_W), .CODE_W(CODE_W), .MUX_ONEHOT(MUX_ONEHOT)
   ) u_mux (
      .src  (src),
      .code (code_q),
      .slice(slice)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_dout <= '0;
      else         lane_dout <= slice;
   end

   // R1: output is held at zero through reset
   a_r1_out_cleared: assert property (@(posedge clk_i)
      !rst_ni |=> (lane_dout == '0));

   // R3: with the shallowest code held, output bit 1 repeats input bit 0 from the previous edge
   a_r3_shallow_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && code_q == '0) |=> (lane_dout[1] == $past(lane_din[0])));
endmodule

// File: tb/tb_lane_bit_aligner.sv
`timescale 1ns/1ps
module tb_lane_bit_aligner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] din = '0;
   logic [3:0] code = 4'd7;
   logic [4:0] dout;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   bit  sb [0:8191];
   int  k = 0;
   int  eff = 7;
   int  pend = 7;

   always #2.5 clk = ~clk;

   lane_bit_aligner dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .lane_din (din),
      .skew_code(code),
      .lane_dout(dout)
   );

   function automatic bit exp_bit(int pos);
      return (pos < 0) ? 1'b0 : sb[pos];
   endfunction

   task automatic check(string tag, logic [4:0] exp);
      total++;
      if (dout !== exp) begin
         bad++;
         $display("FAIL %s: word %0d dout=%b expected=%b", tag, k, dout, exp);
      end
   endtask

   // Entered and left at a falling edge.
   task automatic do_reset();
      rst_n = 1'b0;
      din   = '0;
      code  = 4'd7;
      repeat (2) @(negedge clk);
      check("R1", 5'b0);
      rst_n = 1'b1;
      k     = 0;
      pend  = 7;
   endtask

   task automatic step(logic [4:0] w, logic [3:0] c, string tag);
      logic [4:0] exp;
      din  = w;
      code = c;
      for (int j = 0; j < 5; j++) sb[5*k + j] = w[j];
      @(posedge clk);
      eff  = pend;
      pend = (c > 4'd14) ? 14 : int'(c);
      @(negedge clk);
      for (int j = 0; j < 5; j++) exp[j] = exp_bit(5*k + j - 1 - eff);
      check(tag, exp);
      k++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R6: nominal code right after reset reaches into empty history
      for (int n = 0; n < 3; n++) step(5'($urandom), 4'd7, "R6");
      // R3, R4, R5: sweep every code, first two words after each switch tagged R5
      for (int c = 0; c < 16; c++) begin
         for (int n = 0; n < 20; n++) begin
            if (n < 2)        step(5'($urandom), 4'(c), "R5");
            else if (c == 15) step(5'($urandom), 4'(c), "R4");
            else              step(5'($urandom), 4'(c), "R3");
         end
      end
      // R1: first edge after reset uses centre code even though 0 is driven
      do_reset();
      step(5'b10101, 4'd0, "R1");
      // R2: walking single ones under the shallowest code expose bit order
      for (int j = 0; j < 5; j++) step(5'(1 << j), 4'd0, "R2");
      step(5'b00000, 4'd0, "R2");
      step(5'b10110, 4'd0, "R2");
      step(5'b00000, 4'd0, "R2");
      // R6: reset in mid stream, then the deepest code sees zeros first
      do_reset();
      for (int n = 0; n < 6; n++) step(5'b11111, 4'd14, "R6");
      // R4: code 15 reaches exactly as deep as 14
      for (int n = 0; n < 6; n++) step(5'($urandom), 4'd15, "R4");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule